// File: doc/BRIEF.md
# Programmable AND-OR Logic Array

This block is a two-level sum-of-products logic element whose personality is loaded at run time. Its first level is a set of product terms. Each term ANDs a chosen literal of every input: the true input, the inverted input, or nothing from that input.

Its second level forms each output as the OR of any subset of the product terms. One term can therefore drive several outputs. A mode input can instead confine each output to a fixed, contiguous slice of the terms, which behaves like an array with a fixed OR plane.

Software or a sequencer loads the block one product-term row per clock through a write port. After that the outputs follow the inputs combinationally, with no clock in the evaluation path.

Top module: `pla_array`

## Requirements
- R1: While `rst_n` is low, every row is cleared to AND codes 2'b00 and OR bits 0. After reset, every output is 0 for every input value.
- R2: The AND code for input i sits at bits [2i+1:2i] of a row. Code 2'b10 requires input i to be 1, and code 2'b01 requires input i to be 0.
- R3: Code 2'b11 removes input i from the term. A term whose codes are all 2'b11 is 1 for every input value.
- R4: Code 2'b00 on any input forces its term to 0, whatever the other codes and the inputs are.
- R5: OR bit o of a row connects that term to output o. An output is the OR of its connected terms, so one term can feed several outputs. An output with no connected terms is 0.
- R6: A write with `prog_we` high stores `prog_and` and `prog_or` into row `prog_row` at the clock edge. The outputs do not change before that edge and follow the new row from that edge on.
- R7: When `pal_mode` is 1, output o can only use terms o*G through o*G+G-1, where G = P/O. OR bits outside that slice are ignored even when they are 1.
- R8: When `pal_mode` is 0, any term can feed any output through its OR bit.
- R9: While `prog_we` is low, the stored rows do not change, whatever the other write port inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the write port |
| rst_n | input | 1 | Asynchronous active-low reset; clears all rows |
| pal_mode | input | 1 | 1 = each output limited to its own term slice |
| prog_we | input | 1 | Row write enable |
| prog_row | input | $clog2(P) | Index of the product-term row to write |
| prog_and | input | 2*I | AND codes, two bits per input |
| prog_or | input | O | OR connections of the row, one bit per output |
| in_vec | input | I | Logic inputs |
| out_vec | output | O | Logic outputs |

## Verification
A corrupted AND code or OR bit shows at the ports only for the input values that reach the damaged term. A bad row can therefore stay hidden until that term is selected. For this reason the bench sweeps the whole input space after every personality change, rather than sampling a few input values. A write that lands in the wrong row, or lands a cycle late, shows on the first input sweep after the write edge. The bench compares against its model on every clock, so such faults appear within one or two cycles. A fault in PAL masking shows only when a row has OR bits outside its slice and `pal_mode` is set, so the bench loads exactly that situation.

// File: rtl/pla_array.sv
module pla_array #(
  parameter int I = 4,
  parameter int P = 16,
  parameter int O = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pal_mode,
  input  logic                 prog_we,
  input  logic [$clog2(P)-1:0] prog_row,
  input  logic [2*I-1:0]       prog_and,
  input  logic [O-1:0]         prog_or,
  input  logic [I-1:0]         in_vec,
  output logic [O-1:0]         out_vec
);
  localparam int G = P / O;

  logic [P-1:0][2*I-1:0] and_pl;
  logic [P-1:0][O-1:0]   or_pl;
  logic [P-1:0]          term;
  logic [O-1:0]          grp_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      and_pl <= '0;
      or_pl  <= '0;
    end else if (prog_we && (int'(prog_row) < P)) begin
      and_pl[prog_row] <= prog_and;
      or_pl[prog_row]  <= prog_or;
    end
  end

  always_comb begin
    for (int p = 0; p < P; p++) begin
      term[p] = 1'b1;
      for (int i = 0; i < I; i++)
        if (!((and_pl[p][2*i+1] & in_vec[i]) | (and_pl[p][2*i] & ~in_vec[i])))
          term[p] = 1'b0;
    end
  end

  always_comb begin
    for (int o = 0; o < O; o++) begin
      out_vec[o] = 1'b0;
      for (int p = 0; p < P; p++)
        if (term[p] && or_pl[p][o] && (!pal_mode || (p / G) == o))
          out_vec[o] = 1'b1;
    end
  end

  genvar go;
  generate
    for (go = 0; go < O; go++) begin : g_grp
      assign grp_any[go] = |term[go*G +: G];
    end
  endgenerate

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (out_vec == '0));
  // R6
  write_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_we && (int'(prog_row) < P)) |=>
      (and_pl[$past(prog_row)] == $past(prog_and)) && (or_pl[$past(prog_row)] == $past(prog_or)));
  // R9
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_we |=> ($stable(and_pl) && $stable(or_pl)));
  // R7
  pal_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pal_mode |-> ((out_vec & ~grp_any) == '0));
  // R5
  out_needs_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vec != '0) |-> (term != '0));
endmodule

// File: tb/pla_array_bench.sv
`timescale 1ns/1ps
module pla_array_bench;
  localparam int I = 4, P = 16, O = 4, G = P / O;
  localparam logic [1:0] T = 2'b10, N = 2'b01, X = 2'b11, K = 2'b00;

  logic clk = 0, rst_n = 0, pal_mode = 0, prog_we = 0;
  logic [3:0] prog_row = 0;
  logic [2*I-1:0] prog_and = 0;
  logic [O-1:0] prog_or = 0, in_vec = 0;
  logic [O-1:0] out_vec;
  int n_cmp = 0, n_bad = 0;
  int m_and [P];
  int m_or [P];

  always #2.5 clk = ~clk;

  pla_array #(.I(I), .P(P), .O(O)) u_pla_array (
    .clk(clk), .rst_n(rst_n), .pal_mode(pal_mode), .prog_we(prog_we),
    .prog_row(prog_row), .prog_and(prog_and), .prog_or(prog_or),
    .in_vec(in_vec), .out_vec(out_vec));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < P; p++) begin m_and[p] = 0; m_or[p] = 0; end
    end else if (prog_we) begin
      m_and[prog_row] = int'(prog_and);
      m_or[prog_row]  = int'(prog_or);
    end
  end

  function automatic int model(input int v, input bit pal);
    int r = 0;
    for (int p = 0; p < P; p++) begin
      bit t = 1;
      for (int i = 0; i < I; i++) begin
        int c = (m_and[p] >> (2*i)) & 3;
        bit b = v[i];
        if (c == 0 || (c == 2 && !b) || (c == 1 && b)) t = 0;
      end
      if (t)
        for (int o = 0; o < O; o++)
          if (m_or[p][o] && (!pal || p / G == o)) r |= (1 << o);
    end
    return r;
  endfunction

  task automatic chk(input string rq, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s in=%h actual=%h expected=%h", rq, in_vec, act, exp);
    end
  endtask

  always @(negedge clk) chk("R6 model", int'(out_vec), model(int'(in_vec), pal_mode));

  task automatic wr(input int row, input logic [7:0] a, input logic [3:0] o);
    @(negedge clk);
    prog_we = 1; prog_row = row[3:0]; prog_and = a; prog_or = o;
    @(negedge clk);
    prog_we = 0;
  endtask

  task automatic clear_all();
    for (int p = 0; p < P; p++) wr(p, 8'h00, 4'h0);
  endtask

  function automatic int gray(input int v);
    bit a = v[3], b = v[2], c = v[1], d = v[0];
    bit w = a | (b & d) | (b & c);
    bit x = b & ~c;
    bit y = b | c;
    bit z = (~a & ~b & ~c & d) | (b & c & d) | (a & ~d) | (~b & c & ~d);
    return {w, x, y, z};
  endfunction

  task automatic sweep(input string rq, input int kind);
    for (int v = 0; v < 16; v++) begin
      bit a = v[3], b = v[2], c = v[1];
      int e;
      in_vec = v[3:0];
      #1;
      case (kind)
        0: e = 0;
        1: e = {(~b & c) | a, (~b & ~c) | (a & b), (a & ~c) | (a & b), a | (~b & ~c)};
        2: e = {1'b0, (a & b & ~c) | (b & c) | (~b & ~c),
                (a & b & c) | (a & ~b) | (~a & b), (a & b) | (~a & ~c)};
        3: e = gray(v);
        4: e = gray(v) | ((v[2]) ? 4'b1111 : 4'b0000);
        default: e = 0;
      endcase
      chk(rq, int'(out_vec), e);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    sweep("R1 reset", 0);

    // R6: row 0 all don't-care to out0; unchanged before edge, set after
    @(negedge clk);
    in_vec = 4'h5; prog_we = 1; prog_row = 0; prog_and = {X, X, X, X}; prog_or = 4'b0001;
    #1 chk("R6 before edge", int'(out_vec), 0);
    @(negedge clk);
    prog_we = 0;
    chk("R6 after edge", int'(out_vec), 1);
    for (int v = 0; v < 16; v++) begin
      in_vec = v[3:0]; #1 chk("R3 all dont-care", int'(out_vec), 1);
    end
    // R4: a single kill code zeroes the term
    wr(0, {X, K, X, X}, 4'b0001);
    for (int v = 0; v < 16; v++) begin
      in_vec = v[3:0]; #1 chk("R4 kill code", int'(out_vec), 0);
    end
    // R9: write port data with we low has no effect
    @(negedge clk);
    prog_row = 0; prog_and = {X, X, X, X}; prog_or = 4'b1111;
    repeat (2) @(negedge clk);
    in_vec = 4'h9; #1 chk("R9 no write", int'(out_vec), 0);

    // R2 R5 shared-term personality, A=in3 B=in2 C=in1
    clear_all();
    wr(0, {T, T, X, X}, 4'b0110);
    wr(1, {X, N, T, X}, 4'b1000);
    wr(2, {T, X, N, X}, 4'b0010);
    wr(3, {X, N, N, X}, 4'b0101);
    wr(4, {T, X, X, X}, 4'b1001);
    sweep("R2 R5 shared terms", 1);

    // R5 seven terms, three outputs sharing ABC and ABC'; out3 unconnected
    clear_all();
    wr(0, {T, T, T, X}, 4'b0011);
    wr(1, {T, T, N, X}, 4'b0101);
    wr(2, {N, X, N, X}, 4'b0001);
    wr(3, {T, N, X, X}, 4'b0010);
    wr(4, {N, T, X, X}, 4'b0010);
    wr(5, {X, T, T, X}, 4'b0100);
    wr(6, {X, N, N, X}, 4'b0100);
    sweep("R5 seven terms", 2);

    // BCD-to-Gray: W=out3 rows12-14, X=out2 row8, Y=out1 rows4-5, Z=out0 rows0-3
    clear_all();
    wr(12, {T, X, X, X}, 4'b1000);
    wr(13, {X, T, X, T}, 4'b1000);
    wr(14, {X, T, T, X}, 4'b1000);
    wr(8,  {X, T, N, X}, 4'b0100);
    wr(4,  {X, T, X, X}, 4'b0010);
    wr(5,  {X, X, T, X}, 4'b0010);
    wr(0,  {N, N, N, T}, 4'b0001);
    wr(1,  {X, T, T, T}, 4'b0001);
    wr(2,  {T, X, X, N}, 4'b0001);
    wr(3,  {X, N, T, N}, 4'b0001);
    sweep("R8 gray array mode", 3);
    pal_mode = 1;
    sweep("R7 gray pal mode", 3);
    // row 4 (term B) now drives all outputs; pal mode must ignore the extra bits
    wr(4, {X, T, X, X}, 4'b1111);
    sweep("R7 out-of-slice ignored", 3);
    pal_mode = 0;
    sweep("R8 cross-slice used", 4);

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule